// File: doc/BRIEF.md
# Halfword command queue

This block is the host-side command queue in front of a drawing engine. The host sees a narrow 16-bit register port. Each 32-bit command reaches the block as two register writes. The upper halfword goes first and is held. The lower halfword follows, completes the word and pushes it into a queue of `DEPTH` entries (512 by default). The drawing engine takes words from the head of the queue through a valid/ready handshake.

To pace itself, the host reads the live number of queued words or the free space. Before writing N commands it waits until the level is at most `DEPTH - N`. A flush control empties the queue. An event register with write-one-to-clear bits records two things: that the engine finished a command, and that a command was dropped because the queue was full. An enable bit gates the completion event onto the interrupt line. An engine status register reports whether drawing is still in progress. Drawing counts as in progress while words are queued or while the engine reports that it is busy.

The halfword assembler is a two-state machine.
- `ASM_IDLE` means no upper half is held. An upper write takes it to `ASM_HALF` (transition *load upper*).
- In `ASM_HALF`, a lower write pushes the assembled word and returns to `ASM_IDLE` (transition *complete*).
- In `ASM_HALF`, a further upper write replaces the held half and stays in `ASM_HALF` (transition *reload*).
- A flush in `ASM_HALF` returns to `ASM_IDLE` and discards the held half (transition *abandon*).
- A lower write in `ASM_IDLE` pushes a word whose upper half is zero (transition *lone lower*), and the state stays `ASM_IDLE`.

Top module: `cmdq_halfword`

## Requirements
- R1: A write to address 0 (upper half) followed by a write to address 1 (lower half) enqueues `{upper, lower}`. Words leave on `cmd_data` in the order they were enqueued.
- R2: A write to address 1 with no upper half pending enqueues a word whose bits 31:16 are zero. A completed command leaves no upper half pending.
- R3: A read of address 5 returns the number of queued words. A read of address 6 returns `DEPTH` minus that number. The level rises by one for each accepted lower write and falls by one in each cycle where `cmd_valid` and `cmd_ready` are both high. The level never exceeds `DEPTH`.
- R4: A lower write while the level equals `DEPTH` is dropped. The queue contents and the level stay as they were, and bit 1 of the event register (address 3) is set.
- R5: A write to address 2 with bit 0 set empties the queue on the next cycle. The level reads 0, `cmd_valid` falls and any pending upper half is discarded. A write to address 2 with bit 0 clear has no effect.
- R6: A pulse on `eng_done` sets bit 0 of the event register. Writing address 3 clears exactly the bits written as 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R7: `irq` is high exactly when event bit 0 is set and enable bit 0 (read/write at address 4) is set.
- R8: The engine status register (address 7) has two bits. Bit 0 is 1 while the queue is non-empty. Bit 1 is 1 while the queue is non-empty or `eng_busy` is high.
- R9: After reset, the level is 0, the free space is `DEPTH`, the event, enable and engine status registers are 0, `cmd_valid` is low and `irq` is low.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds its value and `cmd_valid` stays high, unless a flush is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| cmd_valid | output | 1 | A command word is available at the queue head |
| cmd_ready | input | 1 | Engine accepts the head word |
| cmd_data | output | 32 | Head command word |
| eng_busy | input | 1 | Engine is still drawing |
| eng_done | input | 1 | Engine finished a command (one-cycle pulse) |
| irq | output | 1 | Completion interrupt |

## Verification
Paired halfword writes with distinct upper and lower patterns are checked at the queue head in order. This shows that the halves are not swapped and that words are not reordered. Lone lower writes are mixed with paired writes, and a flush is placed between an upper write and its lower write. Together these show whether the assembler keeps a stale upper half. Filling the queue to exactly `DEPTH` and then writing once more shows whether the extra word is dropped without disturbing the head or the level. A completion event that coincides with its own write-one-to-clear shows the priority of set over clear.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        REG_CMD_UP = 3'd0,
        REG_CMD_DN = 3'd1,
        REG_FLUSH  = 3'd2,
        REG_EVT    = 3'd3,
        REG_EVT_EN = 3'd4,
        REG_LEVEL  = 3'd5,
        REG_ROOM   = 3'd6,
        REG_ENGINE = 3'd7
    } reg_sel_e;

    typedef enum logic {
        ASM_IDLE,
        ASM_HALF
    } asm_state_e;

endpackage

// File: rtl/cmdq_assembler.sv
module cmdq_assembler
    import cmdq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_up,
    input  logic                wr_dn,
    input  logic                flush,
    input  logic [HALF_W-1:0]   wdata,
    output logic                push,
    output logic [2*HALF_W-1:0] push_word
);

    asm_state_e          state_q, state_d;
    logic [HALF_W-1:0]   upper_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ASM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (wr_up) begin
            upper_q <= wdata;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ASM_IDLE: begin
                if (wr_up) state_d = ASM_HALF;           // load upper
            end
            ASM_HALF: begin
                if (flush)      state_d = ASM_IDLE;      // abandon
                else if (wr_dn) state_d = ASM_IDLE;      // complete
                else            state_d = ASM_HALF;      // reload or wait
            end
        endcase
    end

    // outputs
    always_comb begin
        push      = wr_dn;
        push_word = {{HALF_W{1'b0}}, wdata};
        unique case (state_q)
            ASM_IDLE: push_word = {{HALF_W{1'b0}}, wdata};   // lone lower
            ASM_HALF: push_word = {upper_q, wdata};
        endcase
    end

endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              ready,
    output logic              valid,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     level,
    output logic              overflow
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    assign full     = (level == FULL_LVL);
    assign valid    = (level != '0);
    assign do_push  = push && !full;
    assign do_pop   = valid && ready;
    assign overflow = push && full;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/cmdq_events.sv
module cmdq_events (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_in,
    input  logic       ovf_in,
    input  logic       w1c_wr,
    input  logic [1:0] w1c_mask,
    input  logic       en_wr,
    input  logic       en_data,
    output logic [1:0] evt,
    output logic       en,
    output logic       irq
);

    logic [1:0] clr_bits;

    assign clr_bits = w1c_wr ? w1c_mask : 2'b00;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= '0;
            en  <= 1'b0;
        end else begin
            evt <= (evt & ~clr_bits) | {ovf_in, done_in};
            if (en_wr) en <= en_data;
        end
    end

    assign irq = evt[0] & en;

endmodule

// File: rtl/cmdq_halfword.sv
module cmdq_halfword
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [31:0] cmd_data,
    input  logic        eng_busy,
    input  logic        eng_done,
    output logic        irq
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    reg_sel_e      sel;
    logic          wr_up, wr_dn, flush_wr, evt_wr, en_wr;
    logic          push, overflow, en;
    logic [31:0]   push_word;
    logic [CW-1:0] q_count, room;
    logic [1:0]    evt;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_up    = reg_wr && (sel == REG_CMD_UP);
    assign wr_dn    = reg_wr && (sel == REG_CMD_DN);
    assign flush_wr = reg_wr && (sel == REG_FLUSH) && reg_wdata[0];
    assign evt_wr   = reg_wr && (sel == REG_EVT);
    assign en_wr    = reg_wr && (sel == REG_EVT_EN);
    assign room     = FULL_LVL - q_count;

    cmdq_assembler u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_up     (wr_up),
        .wr_dn     (wr_dn),
        .flush     (flush_wr),
        .wdata     (reg_wdata),
        .push      (push),
        .push_word (push_word)
    );

    cmdq_store #(.DEPTH(DEPTH), .WORD_W(32)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_wr),
        .push      (push),
        .push_word (push_word),
        .ready     (cmd_ready),
        .valid     (cmd_valid),
        .head      (cmd_data),
        .level     (q_count),
        .overflow  (overflow)
    );

    cmdq_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_in  (eng_done),
        .ovf_in   (overflow),
        .w1c_wr   (evt_wr),
        .w1c_mask (reg_wdata[1:0]),
        .en_wr    (en_wr),
        .en_data  (reg_wdata[0]),
        .evt      (evt),
        .en       (en),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_CMD_UP, REG_CMD_DN, REG_FLUSH: reg_rdata = '0;
            REG_EVT:    reg_rdata = {14'd0, evt};
            REG_EVT_EN: reg_rdata = {15'd0, en};
            REG_LEVEL:  reg_rdata = 16'(q_count);
            REG_ROOM:   reg_rdata = 16'(room);
            REG_ENGINE: reg_rdata = {14'd0, cmd_valid | eng_busy, cmd_valid};
        endcase
    end

endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
    parameter int DEPTH = 512,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_wr,
    input logic          dn_wr,
    input logic          en_wr,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [31:0]   cmd_data,
    input logic          eng_done,
    input logic          irq,
    input logic [CW-1:0] q_count
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    AST_LEVEL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= FULL_LVL); // R3

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == FULL_LVL && dn_wr && !cmd_ready) |=> (q_count == FULL_LVL)); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> !cmd_valid); // R5

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(eng_done) || $past(en_wr))); // R7

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !flush_wr) |=> (cmd_valid && $stable(cmd_data))); // R10

endmodule

bind cmdq_halfword cmdq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_wr  (flush_wr),
    .dn_wr     (wr_dn),
    .en_wr     (en_wr),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .eng_done  (eng_done),
    .irq       (irq),
    .q_count   (q_count)
);

// File: tb/tb_cmdq_halfword.sv
module tb_cmdq_halfword;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int NVEC       = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        32'hDEAD_BEEF, 32'h0001_8000, 32'hFFFF_0000,
        32'h1234_5678, 32'hA5A5_5A5A, 32'h0000_FFFF
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 0;
    logic [31:0] cmd_data;
    logic        eng_busy = 0;
    logic        eng_done = 0;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_halfword #(.DEPTH(DEPTH)) dut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .cmd_valid, .cmd_ready, .cmd_data, .eng_busy, .eng_done, .irq
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pop();
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9 reset state
        rd(5, v); chk("R9 level", 32'(v), 0);
        rd(6, v); chk("R9 room", 32'(v), DEPTH);
        rd(3, v); chk("R9 event", 32'(v), 0);
        rd(4, v); chk("R9 enable", 32'(v), 0);
        rd(7, v); chk("R9 engine", 32'(v), 0);
        chk("R9 cmd_valid", 32'(cmd_valid), 0);
        chk("R9 irq", 32'(irq), 0);

        // R1 table of paired writes
        for (int i = 0; i < NVEC; i++) begin
            wr(0, VEC[i][31:16]);
            wr(1, VEC[i][15:0]);
        end
        rd(5, v); chk("R3 level after table", 32'(v), NVEC);
        rd(6, v); chk("R3 room after table", 32'(v), DEPTH - NVEC);
        rd(7, v); chk("R8 engine with queued words", 32'(v), 3);
        held = cmd_data;
        @(negedge clk);
        chk("R10 head held", cmd_data, held);
        chk("R10 valid held", 32'(cmd_valid), 1);
        for (int i = 0; i < NVEC; i++) begin
            chk($sformatf("R1 order %0d", i), cmd_data, VEC[i]);
            pop();
            rd(5, v); chk("R3 level after pop", 32'(v), NVEC - 1 - i);
        end
        chk("R3 empty valid", 32'(cmd_valid), 0);

        // R2 lone lower writes
        wr(1, 16'h1234);
        wr(0, 16'hABCD); wr(1, 16'h5555);
        wr(1, 16'h6666);
        chk("R2 lone lower", cmd_data, 32'h0000_1234); pop();
        chk("R2 paired", cmd_data, 32'hABCD_5555); pop();
        chk("R2 after pair", cmd_data, 32'h0000_6666); pop();

        // R8 busy with empty queue
        eng_busy = 1; rd(7, v); chk("R8 busy empty", 32'(v), 2);
        eng_busy = 0; rd(7, v); chk("R8 idle empty", 32'(v), 0);

        // R5 flush
        wr(1, 16'h0011); wr(1, 16'h0022);
        wr(0, 16'h7777);
        wr(2, 16'h0000);
        rd(5, v); chk("R5 flush bit0 clear ignored", 32'(v), 2);
        wr(2, 16'h0001);
        rd(5, v); chk("R5 level after flush", 32'(v), 0);
        chk("R5 valid after flush", 32'(cmd_valid), 0);
        wr(1, 16'h0042);
        chk("R5 pending upper discarded", cmd_data, 32'h0000_0042);
        wr(2, 16'h0001);

        // R6 / R7 events
        eng_done = 1; @(negedge clk); eng_done = 0;
        rd(3, v); chk("R6 done sets bit0", 32'(v), 1);
        chk("R7 irq masked", 32'(irq), 0);
        wr(4, 16'h0001);
        chk("R7 irq enabled", 32'(irq), 1);
        wr(3, 16'h0000);
        rd(3, v); chk("R6 write zero keeps", 32'(v), 1);
        wr(3, 16'h0001);
        rd(3, v); chk("R6 w1c clears", 32'(v), 0);
        chk("R7 irq after clear", 32'(irq), 0);
        eng_done = 1; reg_wr = 1; reg_addr = 3; reg_wdata = 16'h0001;
        @(negedge clk);
        eng_done = 0; reg_wr = 0;
        rd(3, v); chk("R6 set wins", 32'(v), 1);
        wr(3, 16'h0001);
        wr(4, 16'h0000);

        // R4 overflow
        for (int i = 0; i < DEPTH; i++) wr(1, 16'(i));
        rd(5, v); chk("R4 level full", 32'(v), DEPTH);
        rd(6, v); chk("R4 room zero", 32'(v), 0);
        wr(1, 16'hFFFF);
        rd(5, v); chk("R4 level after drop", 32'(v), DEPTH);
        rd(3, v); chk("R4 overflow event", 32'(v), 2);
        chk("R4 head unchanged", cmd_data, 32'h0000_0000);
        pop();
        chk("R4 second word", cmd_data, 32'h0000_0001);
        wr(3, 16'h0002);
        rd(3, v); chk("R6 overflow cleared", 32'(v), 0);
        wr(2, 16'h0001);
        rd(5, v); chk("R5 flush from full", 32'(v), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule